// File: doc/BRIEF.md
# Bit-Slice Magnitude Comparator

This block compares two binary words of a parameterised width and drives two flags: one for "first operand is larger" and one for "first operand is smaller". When the words are equal, neither flag is raised. Nothing is registered, so the result follows the operands combinationally.

The comparison is done by a chain of identical one-bit cells. Each cell passes a two-signal greater/less state to its neighbour. A parameter selects the direction of that chain at build time:

- **Upward:** the state ripples from the least significant bit toward the most significant bit, and a differing bit pair overrides whatever arrives from below.
- **Downward:** the state ripples from the most significant bit toward the least significant bit, and a decision taken higher up is passed through unchanged.

A mode input selects unsigned or two's-complement signed comparison. For signed operands, the two sign bits are exchanged before they enter the chain, so the cells are the same in both modes.

Top module: `mag_cmp_slice`

## Requirements
- R1: `gt_o` and `lt_o` are never both 1 for any operand pair or mode.
- R2: With `signed_i`=0, `gt_o`=1 exactly when `a_i` > `b_i` as unsigned words, and `lt_o`=1 exactly when `a_i` < `b_i`.
- R3: With `signed_i`=1, the operands are read as two's-complement numbers (bit WIDTH-1 is the sign, 1 = negative). `gt_o` and `lt_o` then report signed greater and signed less.
- R4: When `a_i` equals `b_i`, both `gt_o` and `lt_o` are 0 in either mode.
- R5: With CHAIN_DIR=DIR_UP (state flows from bit 0 to bit WIDTH-1), the outputs satisfy R1 to R4.
- R6: With CHAIN_DIR=DIR_DOWN (state flows from bit WIDTH-1 to bit 0), the outputs satisfy R1 to R4. For every input, they equal those of the DIR_UP build.
- R7: Only the highest differing bit position decides the result. Lower bits never override it. Examples: 0x80 against 0x7F gives `gt_o` unsigned and `lt_o` signed, and 0x01 against 0x00 gives `gt_o`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| signed_i | input | 1 | 1 = two's-complement compare, 0 = unsigned compare |
| gt_o | output | 1 | First operand greater than second |
| lt_o | output | 1 | First operand less than second |

## Verification
The bench builds two instances at the default WIDTH of 8, one with CHAIN_DIR=DIR_UP and one with DIR_DOWN, and feeds both the same operands. At eight bits the full space of 65,536 operand pairs can be swept in both modes. This reaches every sign combination, every position of the highest differing bit and every equal pair, and it compares the two chain directions pair by pair against a reference that uses the language's own unsigned and signed comparison.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
  typedef enum logic {
    DIR_UP   = 1'b0,
    DIR_DOWN = 1'b1
  } chain_dir_e;

  typedef struct packed {
    logic gt;
    logic lt;
  } cmp_state_t;
endpackage

// File: rtl/cmp_cell_up.sv
// One slice, state travels LSB -> MSB: local difference overrides incoming state.
module cmp_cell_up (
  input  logic a_i,
  input  logic b_i,
  input  logic gt_i,
  input  logic lt_i,
  output logic gt_o,
  output logic lt_o
);
  logic diff;
  assign diff = a_i ^ b_i;
  assign gt_o = (diff & a_i) | (~diff & gt_i);
  assign lt_o = (diff & b_i) | (~diff & lt_i);

  always_comb begin
    // R1
    if (!(gt_i && lt_i)) up_excl_chk: assert (!(gt_o && lt_o));
  end
endmodule

// File: rtl/cmp_cell_down.sv
// One slice, state travels MSB -> LSB: a decided state passes untouched.
module cmp_cell_down (
  input  logic a_i,
  input  logic b_i,
  input  logic gt_i,
  input  logic lt_i,
  output logic gt_o,
  output logic lt_o
);
  logic open_q;
  assign open_q = ~(gt_i | lt_i);
  assign gt_o = gt_i | (open_q & a_i & ~b_i);
  assign lt_o = lt_i | (open_q & ~a_i & b_i);

  always_comb begin
    // R7
    if (gt_i && !lt_i) dn_hold_chk: assert (gt_o && !lt_o);
  end
endmodule

// File: rtl/cmp_sign_map.sv
// Exchanges the sign bits in signed mode so a negative operand ranks lower.
module cmp_sign_map #(
  parameter int unsigned WIDTH = 8
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             signed_i,
  output logic [WIDTH-1:0] a_o,
  output logic [WIDTH-1:0] b_o
);
  localparam int unsigned MSB = WIDTH - 1;

  if (WIDTH > 1) begin : g_wide
    assign a_o[MSB-1:0] = a_i[MSB-1:0];
    assign b_o[MSB-1:0] = b_i[MSB-1:0];
  end
  assign a_o[MSB] = signed_i ? b_i[MSB] : a_i[MSB];
  assign b_o[MSB] = signed_i ? a_i[MSB] : b_i[MSB];
endmodule

// File: rtl/cmp_chain.sv
module cmp_chain
  import cmp_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter chain_dir_e  CHAIN_DIR = DIR_UP
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output cmp_state_t       res_o
);
  localparam int unsigned MSB = WIDTH - 1;

  for (genvar i = 0; i < WIDTH; i++) begin : stg
    logic g_in, l_in, g, l;
    if (CHAIN_DIR == DIR_UP) begin : g_up
      if (i == 0) begin : g_head
        assign g_in = 1'b0;
        assign l_in = 1'b0;
      end else begin : g_link
        assign g_in = stg[i-1].g;
        assign l_in = stg[i-1].l;
      end
      cmp_cell_up u_cell (
        .a_i (a_i[i]),
        .b_i (b_i[i]),
        .gt_i(g_in),
        .lt_i(l_in),
        .gt_o(g),
        .lt_o(l)
      );
    end else begin : g_dn
      if (i == MSB) begin : g_head
        assign g_in = 1'b0;
        assign l_in = 1'b0;
      end else begin : g_link
        assign g_in = stg[i+1].g;
        assign l_in = stg[i+1].l;
      end
      cmp_cell_down u_cell (
        .a_i (a_i[i]),
        .b_i (b_i[i]),
        .gt_i(g_in),
        .lt_i(l_in),
        .gt_o(g),
        .lt_o(l)
      );
    end
  end

  if (CHAIN_DIR == DIR_UP) begin : g_out_up
    assign res_o.gt = stg[MSB].g;
    assign res_o.lt = stg[MSB].l;
  end else begin : g_out_dn
    assign res_o.gt = stg[0].g;
    assign res_o.lt = stg[0].l;
  end
endmodule

// File: rtl/mag_cmp_slice.sv
module mag_cmp_slice
  import cmp_pkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter chain_dir_e  CHAIN_DIR = DIR_UP
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             signed_i,
  output logic             gt_o,
  output logic             lt_o
);
  localparam int unsigned MSB = WIDTH - 1;

  logic [WIDTH-1:0] a_m, b_m;
  cmp_state_t       res;

  cmp_sign_map #(.WIDTH(WIDTH)) u_map (
    .a_i     (a_i),
    .b_i     (b_i),
    .signed_i(signed_i),
    .a_o     (a_m),
    .b_o     (b_m)
  );

  cmp_chain #(.WIDTH(WIDTH), .CHAIN_DIR(CHAIN_DIR)) u_chain (
    .a_i  (a_m),
    .b_i  (b_m),
    .res_o(res)
  );

  assign gt_o = res.gt;
  assign lt_o = res.lt;

  always_comb begin
    // R1
    no_both_chk: assert (!(gt_o && lt_o));
    // R4
    if (a_i == b_i) eq_quiet_chk: assert (!gt_o && !lt_o);
    // R2
    if (!signed_i && (a_i[MSB] != b_i[MSB])) msb_dec_chk: assert (gt_o == a_i[MSB] && lt_o == b_i[MSB]);
    // R3
    if (signed_i && (a_i[MSB] != b_i[MSB])) sign_dec_chk: assert (lt_o == a_i[MSB] && gt_o == b_i[MSB]);
  end
endmodule

// File: tb/mag_cmp_slice_test.sv
module mag_cmp_slice_test;
  import cmp_pkg::*;

  localparam int unsigned W = 8;

  typedef struct {
    string  tag;
    logic   gt;
    logic   lt;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic   sm;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic [W-1:0] a = '0, b = '0;
  logic         sm = 1'b0;
  logic         gt_up, lt_up, gt_dn, lt_dn;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  exp_t q[$];

  mag_cmp_slice #(.WIDTH(W), .CHAIN_DIR(DIR_UP)) uut (
    .a_i(a), .b_i(b), .signed_i(sm), .gt_o(gt_up), .lt_o(lt_up)
  );
  mag_cmp_slice #(.WIDTH(W), .CHAIN_DIR(DIR_DOWN)) uut_dn (
    .a_i(a), .b_i(b), .signed_i(sm), .gt_o(gt_dn), .lt_o(lt_dn)
  );

  task automatic drive(input logic [W-1:0] av, input logic [W-1:0] bv,
                       input logic smv, input string tag);
    exp_t e;
    @(posedge clk);
    a  = av;
    b  = bv;
    sm = smv;
    e.a = av; e.b = bv; e.sm = smv;
    if (smv) begin
      e.gt = $signed(av) > $signed(bv);
      e.lt = $signed(av) < $signed(bv);
    end else begin
      e.gt = av > bv;
      e.lt = av < bv;
    end
    e.tag = tag;
    q.push_back(e);
  endtask

  task automatic cmp(input string tag, input string who, input exp_t e,
                     input logic g, input logic l);
    checks++;
    if (g !== e.gt || l !== e.lt) begin
      errors++;
      $display("FAIL %s %s a=%h b=%h signed=%0b actual gt=%0b lt=%0b expected gt=%0b lt=%0b",
               tag, who, e.a, e.b, e.sm, g, l, e.gt, e.lt);
    end
  endtask

  // Monitor: pops expected items half a cycle after they were driven.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        cmp({e.tag, "/R5"}, "up", e, gt_up, lt_up);
        cmp({e.tag, "/R6"}, "down", e, gt_dn, lt_dn);
        checks++;
        if ((gt_up && lt_up) || (gt_dn && lt_dn)) begin
          errors++;
          $display("FAIL R1 both flags set a=%h b=%h actual up=%0b%0b dn=%0b%0b expected not 11",
                   e.a, e.b, gt_up, lt_up, gt_dn, lt_dn);
        end
      end
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    // R4: quiet outputs with zero operands after start-up
    #1;
    checks++;
    if (gt_up || lt_up || gt_dn || lt_dn) begin
      errors++;
      $display("FAIL R4 initial state actual %0b%0b%0b%0b expected 0000", gt_up, lt_up, gt_dn, lt_dn);
    end
    rst_ni = 1'b1;
    // R7 boundaries
    drive(8'h80, 8'h7F, 1'b0, "R7");
    drive(8'h80, 8'h7F, 1'b1, "R7");
    drive(8'h01, 8'h00, 1'b0, "R7");
    drive(8'h00, 8'h01, 1'b1, "R7");
    drive(8'hFF, 8'h00, 1'b1, "R3");
    drive(8'h7F, 8'h80, 1'b1, "R3");
    drive(8'hFF, 8'hFF, 1'b0, "R4");
    // Exhaustive sweep, both modes
    for (int m = 0; m < 2; m++) begin
      for (int i = 0; i < (1 << W); i++) begin
        for (int j = 0; j < (1 << W); j++) begin
          string t;
          if (i == j) t = "R4";
          else if (m == 1) t = "R3";
          else t = "R2";
          drive(W'(i), W'(j), m[0], t);
        end
      end
    end
    repeat (3) @(posedge clk);
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual cycles=%0d expected completion", cyc);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule